// File: doc/BRIEF.md
# Watchdog Timer with Protection Mode

This block is a watchdog down-counter that software services through a small byte-wide register bus. It has three registers. A write to the start register sets the counter running. Software keeps the system alive by writing the refresh register twice in a row, first 00h and then FFh, which reloads the counter. If the counter is allowed to run past zero, the block raises a one-cycle system reset request and then halts.

A control register holds one sticky bit, the protection enable. Software can only set it with a two-write sequence, and software can never clear it. The bit can also come up set out of reset, depending on a configuration input. While the bit is set, the counter reloads to a shorter value. It then counts on a dedicated low-speed tick instead of the prescaled system clock, so a failure in the main clock setup cannot stop the watchdog.

Top module: `wdt_guard`

## Requirements
- R1: In reset, `rst_req` and `bus_rdata` are 0. The control register (offset 1Ch) resets to 80h when `boot_guard_n` is 0 and to 00h when it is 1.
- R2: A write of 00h to the refresh register (offset 0Dh), followed on the very next bus write by FFh to the same offset, reloads the counter in the cycle of the FFh write. The reload happens whether or not the counter is running.
- R3: A write of FFh to the refresh register does nothing in these cases: no 00h refresh write came before it, or any other bus write came between the 00h and the FFh. Bus reads do not break the sequence.
- R4: Any write to the start register (offset 0Eh) loads the counter and sets it running, whatever the data value. After reset with the protection enable clear, the counter does not run until such a write.
- R5: The counter loads RELOAD_NORM while the protection enable is 0 and RELOAD_PROT while it is 1. After a load at clock edge k, with ticks arriving every T cycles, the reset request rises at edge k+(load+1)*T.
- R6: Bit 7 of the control register becomes 1 only when a control write with bit 7 = 0 is immediately followed, as the next bus write, by a control write with bit 7 = 1. Setting the bit loads RELOAD_PROT and starts the counter.
- R7: Once set, the protection enable stays 1 until reset, whatever is written.
- R8: A read (`bus_re`) returns data on `bus_rdata` in the next cycle. The control register reads as {enable, 7'b0}. The refresh register, the start register and any unmapped offset read 00h. The output is 00h in any cycle that does not follow a read.
- R9: While the protection enable is 0, the counter steps once every PRESCALE system clocks, and the prescaler restarts on every load. While it is 1, the counter steps only on cycles where `slow_tick` is 1.
- R10: On a tick with the counter at 0, `rst_req` is high for exactly one cycle. The counter then stays stopped, and refresh writes do not restart it, until a start write.
- R11: When the protection enable comes out of reset set, the counter starts running from RELOAD_PROT right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_guard_n | input | 1 | Configuration: 0 makes the protection enable reset to 1 |
| slow_tick | input | 1 | Low-speed clock enable, used while protection is enabled |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request on underflow |

## Verification
The assertions check the following on every cycle:
- the reset request lasts a single cycle and leaves the counter stopped;
- the counter holds still while halted, and in protection mode when `slow_tick` is low;
- the protection enable never falls, and starts the counter when it rises;
- reserved read bits stay 0;
- a completed refresh lands on the reload value for the current mode.

Some behaviours only the bench scenarios can show:
- the exact cycles to underflow for each reload value and tick source;
- that broken or incomplete unlock sequences change nothing;
- both reset values of the control register;
- that the counter runs straight out of reset in protected boot.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 8;

  localparam logic [7:0] OFS_REFRESH = 8'h0D;
  localparam logic [7:0] OFS_START   = 8'h0E;
  localparam logic [7:0] OFS_CTRL    = 8'h1C;

  localparam logic [DW-1:0] KEY_ARM  = 8'h00;
  localparam logic [DW-1:0] KEY_FIRE = 8'hFF;

  localparam int PROT_BIT = 7;

  typedef enum logic {
    UL_IDLE  = 1'b0,
    UL_ARMED = 1'b1
  } unlock_t;
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_guard_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          refresh_p,
  output logic          start_p,
  output logic          protset_p,
  output logic          prot_en,
  output logic [DW-1:0] bus_rdata
);
  localparam logic [AW-1:0] A_REF   = AW'(OFS_REFRESH);
  localparam logic [AW-1:0] A_START = AW'(OFS_START);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);

  unlock_t ref_st;
  logic    prot_arm;
  logic    hit_ref, hit_start, hit_ctrl;

  assign hit_ref   = bus_we && (bus_addr == A_REF);
  assign hit_start = bus_we && (bus_addr == A_START);
  assign hit_ctrl  = bus_we && (bus_addr == A_CTRL);

  assign refresh_p = hit_ref && (bus_wdata == KEY_FIRE) && (ref_st == UL_ARMED);
  assign start_p   = hit_start;
  assign protset_p = hit_ctrl && bus_wdata[PROT_BIT] && prot_arm && !prot_en;

  // refresh unlock: any write other than 00h to the refresh offset disarms
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_st <= UL_IDLE;
    end else if (bus_we) begin
      ref_st <= (hit_ref && bus_wdata == KEY_ARM) ? UL_ARMED : UL_IDLE;
    end
  end

  // protection arm: last write was to control with the enable bit low
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_arm <= 1'b0;
    end else if (bus_we) begin
      prot_arm <= hit_ctrl && !bus_wdata[PROT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en <= !boot_guard_n;
    end else if (protset_p) begin
      prot_en <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re && bus_addr == A_CTRL) begin
      bus_rdata <= {prot_en, {(DW-1){1'b0}}};
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic prot_en,
  input  logic slow_tick,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic sys_tick;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign sys_tick = 1'b1;
    end else begin : g_div
      localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || restart) begin
          pre <= '0;
        end else if (pre == PMAX) begin
          pre <= '0;
        end else begin
          pre <= pre + 1'b1;
        end
      end
      assign sys_tick = (pre == PMAX);
    end
  endgenerate

  assign tick = prot_en ? slow_tick : sys_tick;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int          CW          = 16,
  parameter logic [CW-1:0] RELOAD_NORM = 16'h7FFF,
  parameter logic [CW-1:0] RELOAD_PROT = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_prot,
  input  logic          load,
  input  logic          load_prot,
  input  logic          go,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= rst_prot ? RELOAD_PROT : RELOAD_NORM;
      running <= rst_prot;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        cnt <= load_prot ? RELOAD_PROT : RELOAD_NORM;
        if (go) running <= 1'b1;
      end else if (running && tick) begin
        if (cnt == '0) begin
          rst_req <= 1'b1;
          running <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            CW          = 16,
  parameter int            PRESCALE    = 128,
  parameter logic [CW-1:0] RELOAD_NORM = 16'h7FFF,
  parameter logic [CW-1:0] RELOAD_PROT = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_guard_n,
  input  logic          slow_tick,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          rst_req
);
  logic          refresh_p, start_p, protset_p, prot_q;
  logic          load_p, go_p, tick;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign load_p = refresh_p | start_p | protset_p;
  assign go_p   = start_p | protset_p;

  wdt_regif #(.AW(AW)) u_regif (
    .clk(clk), .rst(rst), .boot_guard_n(boot_guard_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .refresh_p(refresh_p), .start_p(start_p), .protset_p(protset_p),
    .prot_en(prot_q), .bus_rdata(bus_rdata)
  );

  wdt_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .restart(load_p), .prot_en(prot_q),
    .slow_tick(slow_tick), .tick(tick)
  );

  wdt_count #(.CW(CW), .RELOAD_NORM(RELOAD_NORM), .RELOAD_PROT(RELOAD_PROT)) u_count (
    .clk(clk), .rst(rst), .rst_prot(!boot_guard_n),
    .load(load_p), .load_prot(prot_q | protset_p), .go(go_p), .tick(tick),
    .cnt(cnt_q), .running(run_q), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int            CW          = 16,
  parameter logic [CW-1:0] RELOAD_NORM = 16'h7FFF,
  parameter logic [CW-1:0] RELOAD_PROT = 16'h0FFF
) (
  input logic          clk,
  input logic          rst,
  input logic          rst_req,
  input logic [7:0]    bus_rdata,
  input logic [CW-1:0] cnt,
  input logic          running,
  input logic          prot_en,
  input logic          refresh_p,
  input logic          load_p,
  input logic          slow_tick
);
  localparam logic [CW-1:0] CMAX = (RELOAD_NORM > RELOAD_PROT) ? RELOAD_NORM : RELOAD_PROT;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R10
  AST_REQ_HALTS: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !running); // R10
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!running && !load_p) |=> $stable(cnt)); // R10
  AST_SLOW_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (prot_en && running && !slow_tick && !load_p) |=> $stable(cnt)); // R9
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (rst)
    prot_en |=> prot_en); // R7
  AST_PROT_STARTS: assert property (@(posedge clk) disable iff (rst)
    $rose(prot_en) |-> running); // R6
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[6:0] == 7'd0); // R8
  AST_REFRESH_VALUE: assert property (@(posedge clk) disable iff (rst)
    refresh_p |=> cnt == ($past(prot_en) ? RELOAD_PROT : RELOAD_NORM)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CMAX); // R5
endmodule

bind wdt_guard wdt_guard_chk #(
  .CW(CW), .RELOAD_NORM(RELOAD_NORM), .RELOAD_PROT(RELOAD_PROT)
) u_chk (
  .clk(clk), .rst(rst), .rst_req(rst_req), .bus_rdata(bus_rdata),
  .cnt(cnt_q), .running(run_q), .prot_en(prot_q),
  .refresh_p(refresh_p), .load_p(load_p), .slow_tick(slow_tick)
);

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int PS = 3;
  localparam int RN = 12;
  localparam int RP = 5;
  localparam int EXP_N = (RN + 1) * PS;
  localparam int EXP_P = RP + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_guard_n = 1'b1;
  logic       slow_tick = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_req;

  int cyc = 0;
  int t_last = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard #(.AW(AW), .CW(CW), .PRESCALE(PS),
              .RELOAD_NORM(8'(RN)), .RELOAD_PROT(8'(RP))) u0 (
    .clk(clk), .rst(rst), .boot_guard_n(boot_guard_n), .slow_tick(slow_tick),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk);
    rst = 1'b1;
    boot_guard_n = cfg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rst_req in reset", int'(rst_req), 0);
    check("R1 rdata in reset", int'(bus_rdata), 0);
    rst = 1'b0;
    t_last = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    t_last = cyc;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk);
    #1;
    bus_re = 1'b0;
    v = int'(bus_rdata);
  endtask

  // cycles from edge t_ref to the edge that raised rst_req; -1 if none
  task automatic wait_req(input int t_ref, input int maxc, output int d);
    d = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (rst_req) begin
        d = cyc - t_ref;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, d, t0;
    logic [7:0] sdat [8] = '{8'h00, 8'h01, 8'h55, 8'hAA, 8'hFF, 8'h7F, 8'h80, 8'h0D};

    // protected-mode scenarios, normal boot
    do_reset(1'b1);
    rd(8'h1C, v); check("R1 ctrl reset 00h", v, 0);
    wait_req(t_last, 60, d); check("R4 idle until start", d, -1);
    wr(8'h1C, 8'h80); rd(8'h1C, v); check("R6 set without arm", v, 0);
    wr(8'h1C, 8'h00); wr(8'h20, 8'h00); wr(8'h1C, 8'h80);
    rd(8'h1C, v); check("R6 arm broken by other write", v, 0);
    slow_tick = 1'b1;
    wr(8'h1C, 8'h00); wr(8'h1C, 8'h80); t0 = t_last;
    wait_req(t0, 200, d); check("R6 prot set loads RP and starts", d, EXP_P);
    @(negedge clk); check("R10 pulse one cycle", int'(rst_req), 0);
    rd(8'h1C, v); check("R6 ctrl reads 80h", v, 8'h80);
    wr(8'h1C, 8'h00); wr(8'h1C, 8'h7F); rd(8'h1C, v); check("R7 enable sticky", v, 8'h80);
    slow_tick = 1'b0;
    wr(8'h0E, 8'h3C);
    wait_req(t_last, 60, d); check("R9 no slow tick no step", d, -1);
    slow_tick = 1'b1;
    wr(8'h0D, 8'h00); wr(8'h0D, 8'hFF); t0 = t_last;
    wait_req(t0, 200, d); check("R2 refresh in prot mode", d, EXP_P);

    // protected boot
    do_reset(1'b0);
    t0 = t_last;
    wait_req(t0, 200, d); check("R11 runs from reset", d, EXP_P);
    rd(8'h1C, v); check("R1 ctrl reset 80h", v, 8'h80);

    // normal boot, slow_tick high but ignored
    do_reset(1'b1);
    slow_tick = 1'b1;
    wait_req(t_last, 60, d); check("R4 not running after reset", d, -1);
    foreach (sdat[i]) begin
      wr(8'h0E, sdat[i]); t0 = t_last;
      wait_req(t0, 400, d); check("R4 R5 R9 start to underflow", d, EXP_N);
      @(negedge clk); check("R10 pulse one cycle", int'(rst_req), 0);
    end
    wr(8'h0D, 8'h00); wr(8'h0D, 8'hFF);
    wait_req(t_last, 80, d); check("R10 refresh does not restart", d, -1);

    wr(8'h0E, 8'h00); idle(20);
    wr(8'h0D, 8'h00); wr(8'h0D, 8'hFF); t0 = t_last;
    wait_req(t0, 400, d); check("R2 refresh reloads RN", d, EXP_N);

    wr(8'h0E, 8'h00); t0 = t_last; idle(4);
    wr(8'h0D, 8'hFF);
    wait_req(t0, 400, d); check("R3 FFh alone ignored", d, EXP_N);

    wr(8'h0E, 8'h00); t0 = t_last; idle(5);
    wr(8'h0D, 8'h00); wr(8'h20, 8'h55); wr(8'h0D, 8'hFF);
    wait_req(t0, 400, d); check("R3 intervening write cancels", d, EXP_N);

    wr(8'h0E, 8'h00); idle(5);
    wr(8'h0D, 8'h00); rd(8'h0D, v); wr(8'h0D, 8'hFF); t0 = t_last;
    wait_req(t0, 400, d); check("R3 read keeps sequence", d, EXP_N);

    // read sweep with enable clear
    for (int a = 0; a < 64; a++) begin
      rd(8'(a), v);
      check("R8 read value", v, 0);
      @(negedge clk); check("R8 idle rdata", int'(bus_rdata), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule